// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes a two-bank SDR SDRAM from power-up to a usable state. After reset it keeps the clock enable and data mask lines high and puts NOP on the command bus for a hold interval. The length of that interval comes from a clock-frequency parameter and a microsecond parameter. It then closes both banks with a precharge-all. Next come the auto-refresh commands and a mode register load, in an order chosen by configuration. The mode register load carries a 10-bit opcode on the low address lines. After the final spacing window has run out, a ready flag is raised for the memory controller that sits downstream.

The opcode, the refresh count and the order select are taken in while reset is asserted, so the whole sequence runs from one fixed configuration. A refresh count below two is raised to two. Each command is followed by a spacing window measured in clock cycles, and NOP commands fill the window. The mode register load is gated by a per-bank idle tracker, so it is never issued while a bank may be open.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, the outputs go to NOP (cs_n, ras_n, cas_n, we_n = 0,1,1,1) with `ready` low. Releasing `rst` restarts the whole sequence, hold interval included.
- R2: The first command is precharge-all (cs_n, ras_n, cas_n, we_n = 0,0,1,0; addr[10] = 1; other address bits 0). It is driven exactly CLK_MHZ*HOLD_US cycles after the first clock edge with `rst` low, and only NOP comes before it.
- R3: `cke` and `dqm` are high in every cycle.
- R4: The number of auto-refresh commands (0,0,0,1; address 0) equals the latched refresh count, or two if that count is below two. Consecutive refresh-to-next-command spacing is TRC cycles.
- R5: The command after the precharge-all comes exactly TRP cycles after it.
- R6: The mode register load is driven as 0,0,0,0, with addr[9:0] equal to the latched opcode, the upper address bits 0 and `bank` 0.
- R7: With `cfg_mrs_first` = 1, the mode register load comes directly after the precharge-all and before the refreshes. With 0, it comes after the last refresh.
- R8: The mode register load is issued only after a precharge-all since reset, that is, only when both banks are idle.
- R9: No command other than NOP follows a mode register load within TMRD (at least 2) cycles. The next command or ready comes exactly TMRD cycles later.
- R10: `ready` rises exactly one spacing window (TRC or TMRD) after the final command. It then stays high with NOP on the bus until reset.
- R11: Configuration inputs are sampled only while `rst` is high. Changes after release do not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_opcode | input | OP_W | Mode register opcode, latched in reset |
| cfg_ref_count | input | REF_W | Requested refresh count, latched in reset |
| cfg_mrs_first | input | 1 | 1: mode load before refreshes |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| cs_n | output | 1 | Chip select, low active |
| ras_n | output | 1 | Row strobe, low active |
| cas_n | output | 1 | Column strobe, low active |
| we_n | output | 1 | Write enable, low active |
| addr | output | ADDR_W | Address bus |
| bank | output | BA_W | Bank select |
| ready | output | 1 | Initialization complete |

## Verification
Edge 0 is the first rising edge with reset low. Every command decision is registered once, so a command chosen at edge E is on the pins until edge E+1. The precharge-all is due at edge CLK_MHZ*HOLD_US. Each later command, and the rise of ready, is due at the previous command's edge plus its spacing window. The bench builds a list of (edge, command, address) entries from the latched configuration. It samples the pins on the falling edge while tracking the edge index, so every command and the ready transition are compared against the exact edge on which they are due.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } init_cmd_e;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_MRS  = 3'd1,
    ST_REF  = 3'd2,
    ST_FIN  = 3'd3,
    ST_DONE = 3'd4
  } init_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_init_bank_track.sv
module sdram_init_bank_track #(
  parameter int NBANK = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pre_all,
  output logic all_idle
);
  logic [NBANK-1:0] idle_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        idle_q[b] <= 1'b0;
      end else if (pre_all) begin
        idle_q[b] <= 1'b1;
      end
    end
  end

  assign all_idle = &idle_q;
endmodule

// File: rtl/sdram_init_cmd_out.sv
module sdram_init_cmd_out
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  init_cmd_e         cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   bank
);
  logic [3:0] code;

  always_comb begin
    unique case (cmd)
      CMD_PRE: code = 4'b0010;
      CMD_REF: code = 4'b0001;
      CMD_MRS: code = 4'b0000;
      default: code = 4'b0111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke  <= 1'b1;
      dqm  <= 1'b1;
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      addr <= '0;
      bank <= '0;
    end else begin
      cke  <= 1'b1;
      dqm  <= 1'b1;
      {cs_n, ras_n, cas_n, we_n} <= code;
      addr <= cmd_addr;
      bank <= '0;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int HOLD_US = 100,
  parameter int TRP     = 3,
  parameter int TRC     = 9,
  parameter int TMRD    = 2,
  parameter int OP_W    = 10,
  parameter int REF_W   = 4,
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 1,
  parameter int NBANK   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   cfg_opcode,
  input  logic [REF_W-1:0]  cfg_ref_count,
  input  logic              cfg_mrs_first,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   bank,
  output logic              ready
);
  localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
  localparam int CNT_MAX  = max_of4(HOLD_CYC, TRP, TRC, TMRD);
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int PRE_BIT  = 10;
  localparam int MIN_REF  = 2;

  init_state_e       st, st_n;
  logic [OP_W-1:0]   opcode_q;
  logic              mrs_first_q;
  logic [REF_W-1:0]  ref_left;
  logic              ref_dec;
  logic              ready_set;
  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              all_idle;
  init_cmd_e         issue;
  logic [ADDR_W-1:0] issue_addr;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(HOLD_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  sdram_init_bank_track #(.NBANK(NBANK)) u_banks (
    .clk(clk), .rst(rst), .pre_all(issue == CMD_PRE), .all_idle(all_idle)
  );

  sdram_init_cmd_out #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
    .clk(clk), .rst(rst), .cmd(issue), .cmd_addr(issue_addr),
    .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .bank(bank)
  );

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q    <= cfg_opcode;
      mrs_first_q <= cfg_mrs_first;
      ref_left    <= (cfg_ref_count < REF_W'(MIN_REF)) ? REF_W'(MIN_REF) : cfg_ref_count;
    end else if (ref_dec) begin
      ref_left <= ref_left - 1'b1;
    end
  end

  always_comb begin
    st_n       = st;
    issue      = CMD_NOP;
    issue_addr = '0;
    t_load     = 1'b0;
    t_val      = '0;
    ref_dec    = 1'b0;
    ready_set  = 1'b0;
    if (t_zero) begin
      unique case (st)
        ST_HOLD: begin
          issue               = CMD_PRE;
          issue_addr[PRE_BIT] = 1'b1;
          t_load              = 1'b1;
          t_val               = CNT_W'(TRP - 1);
          st_n                = mrs_first_q ? ST_MRS : ST_REF;
        end
        ST_MRS: begin
          if (all_idle) begin
            issue                  = CMD_MRS;
            issue_addr[OP_W-1:0]   = opcode_q;
            t_load                 = 1'b1;
            t_val                  = CNT_W'(TMRD - 1);
            st_n                   = mrs_first_q ? ST_REF : ST_FIN;
          end
        end
        ST_REF: begin
          issue   = CMD_REF;
          t_load  = 1'b1;
          t_val   = CNT_W'(TRC - 1);
          ref_dec = 1'b1;
          if (ref_left == REF_W'(1)) begin
            st_n = mrs_first_q ? ST_FIN : ST_MRS;
          end
        end
        ST_FIN: begin
          ready_set = 1'b1;
          st_n      = ST_DONE;
        end
        default: st_n = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_HOLD;
      ready <= 1'b0;
    end else begin
      st <= st_n;
      if (ready_set) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int TMRD   = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              dqm,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);
  localparam int GW = $clog2(TMRD + 1) + 1;

  logic          is_nop, is_mrs, is_pre;
  logic          pre_seen;
  logic [GW-1:0] since_mrs;
  logic          rst_q = 1'b0;

  assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_mrs = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      pre_seen  <= 1'b0;
      since_mrs <= GW'(TMRD);
    end else begin
      if (is_pre) pre_seen <= 1'b1;
      if (is_mrs) since_mrs <= GW'(1);
      else if (since_mrs < GW'(TMRD)) since_mrs <= since_mrs + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_nop_R1: assert (is_nop && !ready)
        else $error("reset outputs not idle");
    end
  end

  assert_pins_high_R3: assert property (@(posedge clk) disable iff (rst) (cke && dqm));
  assert_pre_a10_R2: assert property (@(posedge clk) disable iff (rst) is_pre |-> addr[10]);
  assert_mrs_idle_R8: assert property (@(posedge clk) disable iff (rst) is_mrs |-> pre_seen);
  assert_mrs_gap_R9: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> (since_mrs >= GW'(TMRD)));
  assert_ready_stays_R10: assert property (@(posedge clk) disable iff (rst) ready |=> ready);
  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (rst) ready |-> is_nop);
endmodule

bind sdram_init_seq sdram_init_chk #(.TMRD(TMRD), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .ready(ready)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_MHZ = 200;
  localparam int HOLD_US = 1;
  localparam int HOLD    = CLK_MHZ * HOLD_US;
  localparam int TRP     = 3;
  localparam int TRC     = 9;
  localparam int TMRD    = 2;
  localparam int OP_W    = 10;
  localparam int REF_W   = 4;
  localparam int ADDR_W  = 12;

  typedef struct {
    int          t;
    logic [3:0]  code;
    logic [11:0] a;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OP_W-1:0]  cfg_opcode = '0;
  logic [REF_W-1:0] cfg_ref_count = '0;
  logic cfg_mrs_first = 1'b0;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, ready;
  logic [ADDR_W-1:0] addr;
  logic [0:0] bank;

  int   n_run = 0, n_fail = 0;
  int   edge_idx = -1;
  int   exp_ready = 1 << 30;
  bit   finished = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD_US), .TRP(TRP), .TRC(TRC),
                   .TMRD(TMRD), .OP_W(OP_W), .REF_W(REF_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_opcode(cfg_opcode), .cfg_ref_count(cfg_ref_count),
    .cfg_mrs_first(cfg_mrs_first), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .bank(bank), .ready(ready)
  );

  always @(posedge clk) begin
    if (rst) edge_idx <= -1;
    else     edge_idx <= edge_idx + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: builds the expected command list from the requirements
  task automatic build(input logic [OP_W-1:0] op, input int nreq, input bit mf);
    int   e, n;
    exp_t it;
    q.delete();
    n = (nreq < 2) ? 2 : nreq;                       // R4 clamp
    e = HOLD;
    it = '{e, 4'b0010, 12'h400, "R2"}; q.push_back(it);
    e += TRP;
    if (mf) begin
      it = '{e, 4'b0000, {2'b00, op}, "R5 R6 R7 R8"}; q.push_back(it);
      e += TMRD;
      for (int i = 0; i < n; i++) begin
        it = '{e, 4'b0001, 12'h000, (i == 0) ? "R9 R4" : "R4"}; q.push_back(it);
        e += TRC;
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        it = '{e, 4'b0001, 12'h000, (i == 0) ? "R5 R4" : "R4"}; q.push_back(it);
        e += TRC;
      end
      it = '{e, 4'b0000, {2'b00, op}, "R6 R7 R8"}; q.push_back(it);
      e += TMRD;
    end
    exp_ready = e;
  endtask

  // monitor: compares pins against the expected list on falling edges
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (!(cke && dqm)) check(0, "R3", "cke/dqm", {cke, dqm}, 2'b11);
      if (c != 4'b0111) begin
        if (q.size() == 0) begin
          check(0, "R10", "unexpected command", c, 4'b0111);
        end else begin
          exp_t it;
          it = q.pop_front();
          check(edge_idx == it.t, it.tag, "command edge", edge_idx, it.t);
          check(c == it.code, it.tag, "command code", c, it.code);
          check(addr == it.a && bank == 1'b0, it.tag, "address", {bank, addr}, it.a);
        end
      end
      if (ready !== (edge_idx >= exp_ready))
        check(0, "R10", "ready level", ready, edge_idx >= exp_ready);
      else if (edge_idx == exp_ready - 1 || edge_idx == exp_ready)
        check(1, "R10", "ready edge", ready, ready);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic run(input logic [OP_W-1:0] op, input int nreq, input bit mf,
                     input bit late_change, input int abort_at);
    rst = 1'b1;
    exp_ready = 1 << 30;
    cfg_opcode = op; cfg_ref_count = REF_W'(nreq); cfg_mrs_first = mf;
    step(3);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !ready, "R1", "reset outputs",
          {ready, cs_n, ras_n, cas_n, we_n}, 5'b00111);
    check(cke && dqm, "R3", "reset cke/dqm", {cke, dqm}, 2'b11);
    build(op, nreq, mf);
    rst = 1'b0;
    if (late_change) begin
      step(2);
      cfg_opcode = ~op; cfg_ref_count = REF_W'(7); cfg_mrs_first = ~mf;   // R11
    end
    if (abort_at >= 0) begin
      while (edge_idx < abort_at) step(1);
      return;
    end
    while (edge_idx < exp_ready + 4) step(1);
    check(q.size() == 0, late_change ? "R11" : "R4", "commands left", q.size(), 0);
    check(ready, "R10", "ready held", ready, 1);
  endtask

  initial begin
    step(2);
    run(10'h233, 3, 1'b0, 1'b0, -1);
    run(10'h08A, 4, 1'b1, 1'b0, -1);
    run(10'h3FF, 0, 1'b0, 1'b0, -1);   // R4 count below two
    run(10'h155, 1, 1'b1, 1'b0, -1);   // R4 count below two, R7 order
    run(10'h2AA, 2, 1'b0, 1'b1, -1);   // R11 late config change
    run(10'h011, 5, 1'b0, 1'b0, HOLD + TRP + 5);  // R1 abort mid-sequence
    run(10'h1C3, 2, 1'b1, 1'b0, -1);   // R1 restart after abort
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule